// File: doc/BRIEF.md
# Gated Performance Counter Bank

This block holds a hart's 64-bit cycle counter and retired-instruction counter, together with the three small control registers that govern them: a machine-level counter-enable register, a supervisor-level counter-enable register, and a counter-inhibit register. The two counters can be read and written from machine mode. Lower privilege modes can read them only through read-only shadow addresses, and each shadow read is gated by the enable bits of every more-privileged level. The platform real-time value arrives on an input. It is exposed through its own shadow address and can never be frozen. The programmable event counters and their event selectors are hardwired to zero, and a zero selector means no event.

The CSR port is combinational. While `csr_valid_i` is high, the block decodes `csr_addr_i` against `priv_i`. It returns read data and an illegal-access flag in the same cycle. A legal write takes effect at the next clock edge. The enable bits only control access, and the inhibit bits only control counting; neither affects the other's job. A counter write overrides that cycle's increment, so the retirement of the instruction doing the write never lands on top of the written value.

Top module: `perf_ctr_bank`

## Requirements
- R1: After reset, both counters, the machine enable register (0x306), the supervisor enable register (0x106) and the inhibit register (0x320) read as zero.
- R2: The cycle counter at 0xB00 advances by one on every clock edge unless inhibit bit 0 is set. A legal write loads the written value at the next edge with no increment in that edge, and counting resumes from the written value afterwards.
- R3: The instret counter at 0xB02 advances by one on each edge where `retire_i` is high, unless inhibit bit 2 is set. A legal write in the same cycle as a retire pulse leaves exactly the written value.
- R4: Inhibit register 0x320 has bit 0 for cycle, bit 2 for instret and bits 31:3 for event counters. Bit 1 always reads zero. Inhibit bits change no access decision.
- R5: Shadows 0xC00 (cycle), 0xC01 (`time_i`) and 0xC02 (instret) return the live value. Shadows 0xC03 to 0xC1F return zero. Any write to 0xC00 to 0xC1F is illegal.
- R6: Privilege encoding is U=2'b00, S=2'b01, M=2'b11. A read of shadow 0xC00+i is legal from M always. From S it needs bit i of 0x306. From U it needs bit i of both 0x306 and 0x106. Clearing an enable bit never stops a counter.
- R7: Registers 0x306, 0x320, 0xB00, 0xB02, 0xB03 to 0xB1F and 0x323 to 0x33F are illegal from S and U. Register 0x106 is illegal from U.
- R8: Address 0x14D (supervisor timer compare, stored elsewhere) is flagged illegal from U. From S it is flagged illegal when bit 1 of 0x306 is clear. From M it is never flagged. This block always returns zero data for it.
- R9: Event counters 0xB03 to 0xB1F and event selectors 0x323 to 0x33F read zero from M, accept writes without effect, and raise no illegal flag.
- R10: An illegal access returns zero data and changes no state. An address outside the set above returns zero data with `illegal_o` low.
- R11: The time shadow returns `time_i` even when every inhibit bit has been written to one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_i | input | 1 | One instruction retires this cycle |
| priv_i | input | 2 | Current privilege: 00 U, 01 S, 11 M |
| time_i | input | 64 | Platform real-time value |
| csr_valid_i | input | 1 | CSR access this cycle |
| csr_we_i | input | 1 | Access is a write |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 64 | Write data |
| csr_rdata_o | output | 64 | Read data, zero when illegal or not decoded |
| illegal_o | output | 1 | Access raises illegal instruction |

## Verification
The hardest case to reach from the ports is the one where a counter's access control and its counting disagree. One version is a counter that is frozen by the inhibit register but must still be readable through its shadow. The other is a counter whose enable bit is cleared, so a user-mode read faults, yet it must keep advancing. The stimulus loads a known value into a counter and then sets one control register while leaving the other permissive. It then runs a known number of clock edges or retire pulses. Finally it reads the counter from machine mode and through the gated shadow, and compares against values counted in the bench. A write in the same cycle as a retire pulse is driven on purpose to show that the written value wins.

// File: rtl/perf_ctr_bank.sv
module perf_ctr_bank #(
  parameter int XLEN   = 64,
  parameter int CTR_N  = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            retire_i,
  input  logic [1:0]      priv_i,
  input  logic [XLEN-1:0] time_i,
  input  logic            csr_valid_i,
  input  logic            csr_we_i,
  input  logic [11:0]     csr_addr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic            illegal_o
);
  localparam int          IW       = $clog2(CTR_N);
  localparam logic [1:0]  PRV_S    = 2'b01;
  localparam logic [1:0]  PRV_M    = 2'b11;
  localparam logic [11:0] A_MCYC   = 12'hB00;
  localparam logic [11:0] A_MRET   = 12'hB02;
  localparam logic [11:0] A_INH    = 12'h320;
  localparam logic [11:0] A_MEN    = 12'h306;
  localparam logic [11:0] A_SEN    = 12'h106;
  localparam logic [11:0] A_STCMP  = 12'h14D;
  localparam logic [CTR_N-1:0] INH_MASK = ~(CTR_N'(1) << 1);

  logic [XLEN-1:0]  cyc_q, ret_q;
  logic [CTR_N-1:0] men_q, sen_q, inh_q;

  wire [IW-1:0] idx     = csr_addr_i[IW-1:0];
  wire [11-IW:0] page   = csr_addr_i[11:IW];
  wire          is_m    = (priv_i == PRV_M);
  wire          is_s    = (priv_i == PRV_S);
  wire          in_shd  = (page == 12'hC00 >> IW);
  wire          in_mctr = (page == 12'hB00 >> IW);
  wire          in_mevt = (page == 12'h320 >> IW) && (idx >= IW'(3));

  logic            owned, priv_ok, rd_only;
  logic [XLEN-1:0] val;

  always_comb begin
    owned   = 1'b0;
    priv_ok = 1'b1;
    rd_only = 1'b0;
    val     = '0;
    if (in_shd) begin
      owned   = 1'b1;
      rd_only = 1'b1;
      priv_ok = is_m | (is_s & men_q[idx]) | (!is_m & !is_s & men_q[idx] & sen_q[idx]);
      case (idx)
        IW'(0):  val = cyc_q;
        IW'(1):  val = time_i;
        IW'(2):  val = ret_q;
        default: val = '0;
      endcase
    end else if (in_mctr && idx != IW'(1)) begin
      owned   = 1'b1;
      priv_ok = is_m;
      if (idx == IW'(0))      val = cyc_q;
      else if (idx == IW'(2)) val = ret_q;
    end else if (csr_addr_i == A_INH) begin
      owned   = 1'b1;
      priv_ok = is_m;
      val     = XLEN'(inh_q);
    end else if (in_mevt) begin
      owned   = 1'b1;
      priv_ok = is_m;
    end else if (csr_addr_i == A_MEN) begin
      owned   = 1'b1;
      priv_ok = is_m;
      val     = XLEN'(men_q);
    end else if (csr_addr_i == A_SEN) begin
      owned   = 1'b1;
      priv_ok = is_m | is_s;
      val     = XLEN'(sen_q);
    end else if (csr_addr_i == A_STCMP) begin
      owned   = 1'b1;
      priv_ok = is_m | (is_s & men_q[1]);
    end
  end

  assign illegal_o   = csr_valid_i & owned & (~priv_ok | (rd_only & csr_we_i));
  assign csr_rdata_o = (csr_valid_i & owned & ~illegal_o) ? val : '0;

  wire wr_ok  = csr_valid_i & csr_we_i & owned & ~illegal_o;
  wire wr_cyc = wr_ok && csr_addr_i == A_MCYC;
  wire wr_ret = wr_ok && csr_addr_i == A_MRET;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      ret_q <= '0;
    end else begin
      if (wr_cyc)         cyc_q <= csr_wdata_i;
      else if (!inh_q[0]) cyc_q <= cyc_q + XLEN'(1);
      if (wr_ret)                      ret_q <= csr_wdata_i;
      else if (retire_i && !inh_q[2])  ret_q <= ret_q + XLEN'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      men_q <= '0;
      sen_q <= '0;
      inh_q <= '0;
    end else if (wr_ok) begin
      if (csr_addr_i == A_MEN) men_q <= csr_wdata_i[CTR_N-1:0];
      if (csr_addr_i == A_SEN) sen_q <= csr_wdata_i[CTR_N-1:0];
      if (csr_addr_i == A_INH) inh_q <= csr_wdata_i[CTR_N-1:0] & INH_MASK;
    end
  end
endmodule

// File: rtl/perf_ctr_bank_chk.sv
module perf_ctr_bank_chk #(
  parameter int XLEN  = 64,
  parameter int CTR_N = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            retire_i,
  input logic [1:0]      priv_i,
  input logic [XLEN-1:0] time_i,
  input logic            csr_valid_i,
  input logic            csr_we_i,
  input logic [11:0]     csr_addr_i,
  input logic [XLEN-1:0] csr_wdata_i,
  input logic [XLEN-1:0] csr_rdata_o,
  input logic            illegal_o,
  input logic [XLEN-1:0] cyc_q,
  input logic [XLEN-1:0] ret_q,
  input logic [CTR_N-1:0] men_q,
  input logic [CTR_N-1:0] sen_q,
  input logic [CTR_N-1:0] inh_q
);
  wire legal_wr = csr_valid_i && csr_we_i && !illegal_o;
  wire wr_cyc   = legal_wr && csr_addr_i == 12'hB00;
  wire wr_ret   = legal_wr && csr_addr_i == 12'hB02;

  a_r2_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!inh_q[0] && !wr_cyc) |=> cyc_q == $past(cyc_q) + XLEN'(1));
  a_r2_cycle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (inh_q[0] && !wr_cyc) |=> $stable(cyc_q));
  a_r3_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ret |=> ret_q == $past(csr_wdata_i));
  a_r3_retire_step: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_i && !inh_q[2] && !wr_ret) |=> ret_q == $past(ret_q) + XLEN'(1));
  a_r10_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> csr_rdata_o == '0);
  a_r6_user_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_valid_i && priv_i == 2'b00 && csr_addr_i == 12'hC00 && !(men_q[0] && sen_q[0])) |-> illegal_o);
  a_r7_machine_only: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_valid_i && priv_i != 2'b11 && csr_addr_i == 12'h306) |-> illegal_o);
  a_r11_time_live: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_valid_i && csr_addr_i == 12'hC01 && !illegal_o) |-> csr_rdata_o == time_i);
endmodule

bind perf_ctr_bank perf_ctr_bank_chk #(.XLEN(XLEN), .CTR_N(CTR_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .priv_i(priv_i), .time_i(time_i),
  .csr_valid_i(csr_valid_i), .csr_we_i(csr_we_i), .csr_addr_i(csr_addr_i),
  .csr_wdata_i(csr_wdata_i), .csr_rdata_o(csr_rdata_o), .illegal_o(illegal_o),
  .cyc_q(cyc_q), .ret_q(ret_q), .men_q(men_q), .sen_q(sen_q), .inh_q(inh_q));

// File: tb/sim_perf_ctr_bank.sv
`timescale 1ns/1ps
module sim_perf_ctr_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        retire_i = 1'b0;
  logic [1:0]  priv_i = 2'b11;
  logic [63:0] time_i = 64'h0000_00DE_AD00_1234;
  logic        csr_valid_i = 1'b0;
  logic        csr_we_i = 1'b0;
  logic [11:0] csr_addr_i = '0;
  logic [63:0] csr_wdata_i = '0;
  logic [63:0] csr_rdata_o;
  logic        illegal_o;

  int n_run = 0;
  int n_bad = 0;

  localparam logic [1:0] U = 2'b00, S = 2'b01, M = 2'b11;
  localparam logic [15:0] VEC [16] = '{
    {S, 1'b0, 12'hC00, 1'b0}, {S, 1'b0, 12'hC01, 1'b1},
    {S, 1'b0, 12'hC02, 1'b0}, {U, 1'b0, 12'hC00, 1'b0},
    {U, 1'b0, 12'hC02, 1'b1}, {U, 1'b0, 12'hC01, 1'b1},
    {S, 1'b0, 12'hB00, 1'b1}, {M, 1'b0, 12'hC01, 1'b0},
    {U, 1'b0, 12'h106, 1'b1}, {S, 1'b0, 12'h106, 1'b0},
    {S, 1'b0, 12'h306, 1'b1}, {M, 1'b1, 12'hC00, 1'b1},
    {S, 1'b0, 12'h14D, 1'b1}, {M, 1'b0, 12'h14D, 1'b0},
    {S, 1'b0, 12'hC03, 1'b1}, {S, 1'b0, 12'h320, 1'b1}
  };

  perf_ctr_bank u0 (
    .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .priv_i(priv_i), .time_i(time_i),
    .csr_valid_i(csr_valid_i), .csr_we_i(csr_we_i), .csr_addr_i(csr_addr_i),
    .csr_wdata_i(csr_wdata_i), .csr_rdata_o(csr_rdata_o), .illegal_o(illegal_o));

  always #2 clk = ~clk;

  initial begin
    #(4 * 20000);
    n_run++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic op(input logic [1:0] p, input logic we, input logic [11:0] a,
                    input logic [63:0] wd, output logic [63:0] rd, output logic ill);
    @(negedge clk);
    priv_i = p; csr_we_i = we; csr_addr_i = a; csr_wdata_i = wd; csr_valid_i = 1'b1;
    #1 rd = csr_rdata_o; ill = illegal_o;
    @(posedge clk);
    #1 csr_valid_i = 1'b0; csr_we_i = 1'b0;
  endtask

  task automatic pulse_retire();
    @(negedge clk) retire_i = 1'b1;
    @(negedge clk) retire_i = 1'b0;
  endtask

  logic [63:0] d, hold;
  logic        il;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    op(M, 0, 12'h306, 0, d, il); check("R1 reset mcounteren", d, 0);
    op(M, 0, 12'h106, 0, d, il); check("R1 reset scounteren", d, 0);
    op(M, 0, 12'h320, 0, d, il); check("R1 reset inhibit", d, 0);
    op(M, 0, 12'hB02, 0, d, il); check("R1 reset instret", d, 0);

    op(M, 1, 12'hB00, 64'd1000, d, il);
    op(M, 0, 12'hB00, 0, d, il); check("R2 cycle after write", d, 64'd1000);
    op(M, 0, 12'hB00, 0, d, il); check("R2 cycle next edge", d, 64'd1001);
    repeat (4) @(posedge clk);
    op(M, 0, 12'hB00, 0, d, il); check("R2 cycle after 5 more edges", d, 64'd1006);

    retire_i = 1'b1;
    op(M, 1, 12'hB02, 64'd50, d, il);
    retire_i = 1'b0;
    op(M, 0, 12'hB02, 0, d, il); check("R3 write beats retire", d, 64'd50);
    pulse_retire(); pulse_retire(); pulse_retire();
    op(M, 0, 12'hB02, 0, d, il); check("R3 three retires", d, 64'd53);

    op(M, 1, 12'h306, 64'h5, d, il);
    op(M, 1, 12'h106, 64'h1, d, il);
    foreach (VEC[i]) begin
      op(VEC[i][15:14], VEC[i][13], VEC[i][12:1], 64'h0, d, il);
      check($sformatf("R6 R7 R8 access vector %0d illegal", i), {63'b0, il}, {63'b0, VEC[i][0]});
      if (il) check($sformatf("R10 access vector %0d data", i), d, 0);
    end
    op(M, 0, 12'hC01, 0, d, il); check("R5 time shadow", d, time_i);
    op(M, 0, 12'hC07, 0, d, il); check("R5 event shadow zero", d, 0);

    op(M, 1, 12'h306, 64'h7, d, il);
    op(S, 0, 12'h14D, 0, d, il); check("R8 stimecmp from S with TM", {63'b0, il}, 0);
    op(U, 0, 12'h14D, 0, d, il); check("R8 stimecmp from U", {63'b0, il}, 1);

    op(M, 1, 12'h320, 64'h5, d, il);
    op(M, 0, 12'hB00, 0, hold, il);
    repeat (5) @(posedge clk);
    pulse_retire();
    op(M, 0, 12'hB00, 0, d, il); check("R4 inhibited cycle holds", d, hold);
    op(M, 1, 12'h106, 64'h7, d, il);
    op(U, 0, 12'hC00, 0, d, il); check("R4 inhibited cycle still readable", {63'b0, il}, 0);
    check("R4 inhibited cycle shadow value", d, hold);
    op(M, 0, 12'hB02, 0, d, il); check("R4 inhibited instret holds", d, 64'd53);
    op(S, 1, 12'hB00, 64'd77, d, il); check("R10 S write to cycle illegal", {63'b0, il}, 1);
    op(M, 0, 12'hB00, 0, d, il); check("R10 illegal write no effect", d, hold);
    op(M, 0, 12'h300, 0, d, il); check("R10 undecoded no flag", {63'b0, il}, 0);
    check("R10 undecoded data", d, 0);

    op(M, 1, 12'h320, 64'hFFFF_FFFF, d, il);
    op(M, 0, 12'h320, 0, d, il); check("R4 time inhibit bit reads zero", d, 64'hFFFF_FFFD);
    time_i = 64'h1234_5678_9ABC_DEF0;
    op(M, 0, 12'hC01, 0, d, il); check("R11 time not inhibitable", d, 64'h1234_5678_9ABC_DEF0);

    op(M, 1, 12'hB05, 64'd123, d, il); check("R9 event counter write legal", {63'b0, il}, 0);
    op(M, 0, 12'hB05, 0, d, il); check("R9 event counter reads zero", d, 0);
    op(M, 1, 12'h325, 64'd7, d, il);
    op(M, 0, 12'h325, 0, d, il); check("R9 event selector reads zero", d, 0);

    op(M, 1, 12'h320, 64'h0, d, il);
    op(M, 1, 12'h306, 64'h0, d, il);
    op(U, 0, 12'hC02, 0, d, il); check("R6 disabled instret faults from U", {63'b0, il}, 1);
    op(M, 0, 12'hB02, 0, hold, il);
    pulse_retire(); pulse_retire();
    op(M, 0, 12'hB02, 0, d, il); check("R6 disabled instret keeps counting", d, hold + 64'd2);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule